// File: doc/BRIEF.md
# IDE Programmed-I/O Window Decoder

This block sits between a host programmed-I/O request path and a two-channel disk interface. It resolves each I/O address against five relocatable windows. The windows are the command and control blocks of the primary channel, the command and control blocks of the secondary channel, and the bus-master register window. For every request it reports which window was hit, the block type, the channel and the offset inside the window. For command and control accesses it also names one of four drive ports.

Each window has a base register and a size register that are written through a small configuration port. The block snoops writes to the drive-select register of each command block. From them it keeps a per-channel shadow bit that chooses between the master and slave drive. Requests that miss every window, that arrive while I/O decoding is disabled, or that use an illegal width end in a fault response.

A three-state machine produces the response. `ST_IDLE` means no response is presented. `ST_ROUTE` presents a legal decode. `ST_FAULT` presents an error. In every state, a request goes to `ST_ROUTE` when it decodes legally and to `ST_FAULT` when it does not. A cycle with no request goes to `ST_IDLE`. Each state lasts one cycle unless another request follows.

Top module: `ide_window_decoder`

## Requirements
- R1: An address hits window w when base_w != 0, base_w <= addr and addr < base_w + size_w (no wrap). The reported offset is addr - base_w. When windows overlap, the lowest window index wins: 0 primary command, 1 primary control, 2 secondary command, 3 secondary control, 4 bus-master.
- R2: rsp_type is 0 for a command window, 1 for a control window and 2 for the bus-master window. Windows 0 and 1 report rsp_chan 0. Windows 2 and 3 report rsp_chan 1.
- R3: In the bus-master window, rsp_chan is 0 for offsets below BM_SPLIT (8) and 1 otherwise.
- R4: Reset leaves every base at 0, so nothing is mapped. A configuration write with cfg_idx 0..4 loads that window's base and size. A write with cfg_idx 5..7 changes nothing. Writing base 0 unmaps a window.
- R5: While io_en is low, no window matches and every request faults.
- R6: A legal write to a command window at offset SEL_OFF (6) loads that channel's shadow bit from bit 4 of req_wdata. Both shadow bits reset to 0 (master). No other request changes them. They are visible on shadow_dev (bit 0 primary, bit 1 secondary).
- R7: For command and control hits, rsp_drive = chan*2 + shadow bit. A drive-select write is routed using the bit it writes. Bus-master hits and faults report rsp_drive 0.
- R8: req_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = illegal. A 4-byte access to a command or control window is illegal. A 4-byte access to the bus-master window is legal.
- R9: A faulting request responds with rsp_err 1, rsp_type 3, rsp_chan 0, rsp_offset 0 and rsp_drive 0. rsp_ones is 1 only for a faulting read. A faulting write has no side effect.
- R10: Every request produces exactly one response, with rsp_valid high in the cycle after the request. rsp_valid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_en | input | 1 | I/O-space decode enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window index for configuration write |
| cfg_base | input | ADDR_W | Base address to load |
| cfg_size | input | ADDR_W | Window size to load |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request I/O address |
| req_size | input | 2 | Access width code |
| req_wdata | input | 8 | Low write data byte |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request faulted |
| rsp_ones | output | 1 | Read data must be all ones |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_chan | output | 1 | Channel, 0 primary, 1 secondary |
| rsp_type | output | 2 | Block type code |
| rsp_offset | output | ADDR_W | Offset inside the window |
| rsp_drive | output | 2 | Target drive port |
| shadow_dev | output | 2 | Per-channel drive-select shadow bits |

## Verification
The hardest case to reach is a fault that must leave the shadow bits untouched. One example is a drive-select write that lands on the right offset but has an illegal width. Another is a drive-select write sent while decoding is disabled. Both look almost like legal selects. The stimulus sets a known shadow state first, then sends these writes with bit 4 opposite to the stored value. It follows each one with a plain command-block read whose drive number shows the shadow bit at the ports. Window priority is reached by moving the secondary control window on top of the primary command window, then unmapping the primary window.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

    localparam int NWIN  = 5;
    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] W_PCMD = 3'd0;
    localparam logic [IDX_W-1:0] W_PCTL = 3'd1;
    localparam logic [IDX_W-1:0] W_SCMD = 3'd2;
    localparam logic [IDX_W-1:0] W_SCTL = 3'd3;
    localparam logic [IDX_W-1:0] W_BM   = 3'd4;

    typedef enum logic [1:0] {
        BLK_CMD  = 2'd0,
        BLK_CTRL = 2'd1,
        BLK_BM   = 2'd2,
        BLK_NONE = 2'd3
    } blk_t;

    typedef enum logic [1:0] {
        SZ_1   = 2'd0,
        SZ_2   = 2'd1,
        SZ_4   = 2'd2,
        SZ_BAD = 2'd3
    } acc_sz_t;

    function automatic blk_t win_type(input logic [IDX_W-1:0] idx);
        case (idx)
            W_PCMD, W_SCMD: return BLK_CMD;
            W_PCTL, W_SCTL: return BLK_CTRL;
            default:        return BLK_BM;
        endcase
    endfunction

endpackage

// File: rtl/ide_win_bank.sv
module ide_win_bank #(
    parameter int ADDR_W = 16,
    parameter int NWIN   = 5,
    parameter int IDX_W  = 3,
    parameter logic [NWIN-1:0][ADDR_W-1:0] RST_SIZE = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic [ADDR_W-1:0]           cfg_base,
    input  logic [ADDR_W-1:0]           cfg_size,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NWIN-1:0]             hit,
    output logic [NWIN-1:0][ADDR_W-1:0] offs
);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [ADDR_W-1:0] base_q;
        logic [ADDR_W-1:0] size_q;
        logic [ADDR_W:0]   limit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q <= '0;
                size_q <= RST_SIZE[w];
            end else if (cfg_we && cfg_idx == IDX_W'(w)) begin
                base_q <= cfg_base;
                size_q <= cfg_size;
            end
        end

        assign limit   = {1'b0, base_q} + {1'b0, size_q};
        assign hit[w]  = en && (base_q != '0) && (addr >= base_q) &&
                         ({1'b0, addr} < limit);
        assign offs[w] = addr - base_q;
    end

endmodule

// File: rtl/ide_win_pick.sv
module ide_win_pick #(
    parameter int ADDR_W = 16,
    parameter int NWIN   = 5,
    parameter int IDX_W  = 3
) (
    input  logic [NWIN-1:0]             hit,
    input  logic [NWIN-1:0][ADDR_W-1:0] offs,
    output logic                        any,
    output logic [IDX_W-1:0]            idx,
    output logic [ADDR_W-1:0]           off
);

    always_comb begin
        any = |hit;
        idx = '0;
        off = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                idx = IDX_W'(w);
                off = offs[w];
            end
        end
    end

endmodule

// File: rtl/ide_dev_shadow.sv
module ide_dev_shadow (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       chan,
    input  logic       dev_bit,
    output logic [1:0] dev
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev <= 2'b00;
        end else if (upd) begin
            dev[chan] <= dev_bit;
        end
    end

endmodule

// File: rtl/ide_window_decoder.sv
module ide_window_decoder
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int SEL_OFF  = 6,
    parameter int SEL_BIT  = 4,
    parameter int BM_SPLIT = 8,
    parameter int PCMD_SZ  = 8,
    parameter int PCTL_SZ  = 4,
    parameter int SCMD_SZ  = 8,
    parameter int SCTL_SZ  = 4,
    parameter int BM_SZ    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_en,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_size,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_ones,
    output logic              rsp_write,
    output logic              rsp_chan,
    output logic [1:0]        rsp_type,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic [1:0]        rsp_drive,
    output logic [1:0]        shadow_dev
);

    localparam logic [NWIN-1:0][ADDR_W-1:0] RST_SIZES = {
        ADDR_W'(BM_SZ), ADDR_W'(SCTL_SZ), ADDR_W'(SCMD_SZ),
        ADDR_W'(PCTL_SZ), ADDR_W'(PCMD_SZ)
    };

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUTE = 2'd1,
        ST_FAULT = 2'd2
    } st_t;

    st_t state_q, state_d;

    logic [NWIN-1:0]             win_hit;
    logic [NWIN-1:0][ADDR_W-1:0] win_offs;
    logic                        any_hit;
    logic [IDX_W-1:0]            hit_idx;
    logic [ADDR_W-1:0]           hit_off;

    blk_t  dec_type;
    logic  dec_chan;
    logic  size_ok;
    logic  legal;
    logic  sel_wr;
    logic  dev_now;
    logic  [1:0] dec_drive;

    logic              lat_write;
    logic              lat_chan;
    blk_t              lat_type;
    logic [ADDR_W-1:0] lat_off;
    logic [1:0]        lat_drive;

    ide_win_bank #(
        .ADDR_W(ADDR_W), .NWIN(NWIN), .IDX_W(IDX_W), .RST_SIZE(RST_SIZES)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .en(io_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_size(cfg_size),
        .addr(req_addr), .hit(win_hit), .offs(win_offs)
    );

    ide_win_pick #(
        .ADDR_W(ADDR_W), .NWIN(NWIN), .IDX_W(IDX_W)
    ) u_pick (
        .hit(win_hit), .offs(win_offs),
        .any(any_hit), .idx(hit_idx), .off(hit_off)
    );

    ide_dev_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .upd(sel_wr),
        .chan(dec_chan), .dev_bit(req_wdata[SEL_BIT]),
        .dev(shadow_dev)
    );

    // Request decode
    always_comb begin
        dec_type = any_hit ? win_type(hit_idx) : BLK_NONE;
        if (hit_idx == W_BM)
            dec_chan = (hit_off >= ADDR_W'(BM_SPLIT));
        else
            dec_chan = (hit_idx == W_SCMD) || (hit_idx == W_SCTL);
        size_ok = (req_size != SZ_BAD) &&
                  !((req_size == SZ_4) && (dec_type != BLK_BM));
        legal   = any_hit && size_ok;
        sel_wr  = req_valid && req_write && legal &&
                  (dec_type == BLK_CMD) && (hit_off == ADDR_W'(SEL_OFF));
        dev_now = sel_wr ? req_wdata[SEL_BIT] : shadow_dev[dec_chan];
        if ((dec_type == BLK_CMD) || (dec_type == BLK_CTRL))
            dec_drive = {dec_chan, dev_now};
        else
            dec_drive = 2'b00;
    end

    // Next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ROUTE, ST_FAULT: begin
                if (req_valid)
                    state_d = legal ? ST_ROUTE : ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lat_write <= 1'b0;
            lat_chan  <= 1'b0;
            lat_type  <= BLK_NONE;
            lat_off   <= '0;
            lat_drive <= 2'b00;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                lat_write <= req_write;
                lat_chan  <= dec_chan;
                lat_type  <= dec_type;
                lat_off   <= hit_off;
                lat_drive <= dec_drive;
            end
        end
    end

    // Outputs
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_err    = 1'b0;
        rsp_ones   = 1'b0;
        rsp_write  = 1'b0;
        rsp_chan   = 1'b0;
        rsp_type   = BLK_NONE;
        rsp_offset = '0;
        rsp_drive  = 2'b00;
        unique case (state_q)
            ST_IDLE: ;
            ST_ROUTE: begin
                rsp_valid  = 1'b1;
                rsp_write  = lat_write;
                rsp_chan   = lat_chan;
                rsp_type   = lat_type;
                rsp_offset = lat_off;
                rsp_drive  = lat_drive;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
                rsp_write = lat_write;
                rsp_ones  = !lat_write;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ide_dec_checker.sv
module ide_dec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       rsp_ones,
    input logic       rsp_write,
    input logic       rsp_chan,
    input logic [1:0] rsp_type,
    input logic [1:0] rsp_drive,
    input logic [1:0] shadow_dev
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                   // R10
    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));                            // R10
    AST_ERR_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);                                     // R9
    AST_ERR_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_type == 2'd3 && rsp_drive == 2'd0 && !rsp_chan)); // R9
    AST_ONES_ONLY_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ones |-> (rsp_err && !rsp_write));                      // R9
    AST_DRIVE_ON_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_type < 2'd2) |-> (rsp_drive[1] == rsp_chan)); // R7
    AST_BM_DRIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_type == 2'd2) |-> (rsp_drive == 2'd0));   // R7
    AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(shadow_dev));         // R6

endmodule

bind ide_window_decoder ide_dec_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_ones(rsp_ones),
    .rsp_write(rsp_write), .rsp_chan(rsp_chan), .rsp_type(rsp_type),
    .rsp_drive(rsp_drive), .shadow_dev(shadow_dev)
);

// File: tb/test_ide_window_decoder.sv
module test_ide_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_size = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid, rsp_err, rsp_ones, rsp_write, rsp_chan;
    logic [1:0]  rsp_type, rsp_drive, shadow_dev;
    logic [15:0] rsp_offset;

    typedef struct packed {
        logic        err;
        logic        ones;
        logic        wr;
        logic        chan;
        logic [1:0]  typ;
        logic [15:0] off;
        logic [1:0]  drv;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [15:0] mbase [5];
    logic [15:0] msize [5];
    logic [1:0]  mdev;
    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    ide_window_decoder i_ide_window_decoder (
        .clk(clk), .rst_n(rst_n), .io_en(io_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_ones(rsp_ones),
        .rsp_write(rsp_write), .rsp_chan(rsp_chan), .rsp_type(rsp_type),
        .rsp_offset(rsp_offset), .rsp_drive(rsp_drive), .shadow_dev(shadow_dev)
    );

    task automatic predict(input logic w, input logic [15:0] a, input logic [1:0] sz,
                           input logic [7:0] wd, output exp_t e);
        int          hit;
        logic [15:0] off;
        logic        ok;
        hit = -1;
        off = '0;
        e   = '0;
        e.wr = w;
        for (int i = 0; i < 5; i++)
            if (hit < 0 && io_en && mbase[i] != 0 && a >= mbase[i] &&
                {1'b0, a} < {1'b0, mbase[i]} + {1'b0, msize[i]}) begin
                hit = i;
                off = a - mbase[i];
            end
        if (hit >= 0) begin
            e.typ  = (hit == 4) ? 2'd2 : ((hit % 2 == 0) ? 2'd0 : 2'd1);
            e.chan = (hit == 4) ? (off >= 16'd8) : (hit >= 2);
        end
        ok = (hit >= 0) && sz != 2'd3 && !(sz == 2'd2 && e.typ != 2'd2);
        if (!ok) begin
            e.err = 1'b1; e.ones = !w; e.typ = 2'd3; e.chan = 1'b0; e.off = '0; e.drv = '0;
        end else begin
            e.off = off;
            if (e.typ != 2'd2) begin
                if (w && e.typ == 2'd0 && off == 16'd6) mdev[e.chan] = wd[4];
                e.drv = {e.chan, mdev[e.chan]};
            end
        end
    endtask

    task automatic acc(input logic w, input logic [15:0] a, input logic [1:0] sz,
                       input logic [7:0] wd, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
        @(posedge clk);
        predict(w, a, sz, wd, e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic cfg(input int idx, input logic [15:0] b, input logic [15:0] s);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_base = b; cfg_size = s;
        @(posedge clk);
        if (idx < 5) begin mbase[idx] = b; msize[idx] = s; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    total++; fails++;
                    $display("FAIL R10 unexpected response act=1 exp=0");
                end else begin
                    exp_t  e;
                    exp_t  a;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    a = {rsp_err, rsp_ones, rsp_write, rsp_chan, rsp_type, rsp_offset, rsp_drive};
                    total++;
                    if (a !== e || shadow_dev !== mdev) begin
                        fails++;
                        $display("FAIL %s act=%h/%b exp=%h/%b", t, a, shadow_dev, e, mdev);
                    end
                end
            end else if (exp_q.size() != 0) begin
                total++; fails++;
                $display("FAIL R10 missing response act=0 exp=1");
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog act=running exp=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) begin mbase[i] = '0; msize[i] = '0; end
        msize[0] = 8; msize[1] = 4; msize[2] = 8; msize[3] = 4; msize[4] = 16;
        mdev = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0 || shadow_dev !== 2'b00) begin
            fails++;
            $display("FAIL R6 reset act=%b%b exp=000", rsp_valid, shadow_dev);
        end
        rst_n = 1'b1;
        io_en = 1'b1;

        acc(0, 16'h01F0, 2'd0, 8'h00, "R4 unmapped after reset");
        acc(1, 16'h01F6, 2'd0, 8'h10, "R4 unmapped write no effect");
        idle(1);
        cfg(0, 16'h01F0, 16'd8);
        cfg(1, 16'h03F6, 16'd4);
        cfg(2, 16'h0170, 16'd8);
        cfg(3, 16'h0376, 16'd4);
        cfg(4, 16'hC000, 16'd16);

        acc(0, 16'h01F2, 2'd0, 8'h00, "R1 R2 pri cmd");
        acc(0, 16'h01F7, 2'd1, 8'h00, "R1 top edge");
        acc(0, 16'h01F8, 2'd0, 8'h00, "R1 past end");
        acc(0, 16'h01EF, 2'd0, 8'h00, "R1 below base");
        acc(0, 16'h03F6, 2'd1, 8'h00, "R2 pri ctrl");
        acc(0, 16'h0171, 2'd0, 8'h00, "R2 R7 sec cmd");
        acc(1, 16'h01F6, 2'd0, 8'h10, "R6 R7 pri select new bit");
        acc(0, 16'h01F1, 2'd0, 8'h00, "R7 pri master->slave");
        acc(0, 16'h03F6, 2'd0, 8'h00, "R7 pri ctrl slave");
        acc(0, 16'h0377, 2'd0, 8'h00, "R7 sec ctrl master");
        acc(1, 16'h0176, 2'd1, 8'hF0, "R6 sec select");
        acc(0, 16'h0170, 2'd0, 8'h00, "R7 sec slave");
        acc(1, 16'h01F6, 2'd0, 8'hEF, "R6 pri back to master");
        acc(1, 16'h01F6, 2'd2, 8'h10, "R8 R9 4-byte select faults");
        acc(0, 16'h01F0, 2'd0, 8'h00, "R9 shadow unchanged");
        acc(0, 16'h01F0, 2'd2, 8'h00, "R8 4-byte cmd read");
        acc(0, 16'hC004, 2'd3, 8'h00, "R8 size code 3");
        idle(2);
        acc(0, 16'hC000, 2'd2, 8'h00, "R3 R8 bm ch0 4-byte");
        acc(1, 16'hC007, 2'd0, 8'h00, "R3 bm last ch0");
        acc(0, 16'hC008, 2'd2, 8'h00, "R3 bm first ch1");
        acc(0, 16'hC00F, 2'd0, 8'h00, "R3 bm last");
        acc(1, 16'hC010, 2'd0, 8'h00, "R9 write miss");
        idle(1);

        @(negedge clk); io_en = 1'b0;
        acc(0, 16'h01F0, 2'd0, 8'h00, "R5 disabled read");
        acc(1, 16'h0176, 2'd0, 8'h00, "R5 disabled select");
        @(negedge clk); req_valid = 1'b0; io_en = 1'b1;
        acc(0, 16'h0170, 2'd0, 8'h00, "R5 R6 shadow kept");

        cfg(3, 16'h01F4, 16'd4);
        acc(0, 16'h01F5, 2'd0, 8'h00, "R1 overlap priority");
        cfg(0, 16'h0000, 16'd8);
        acc(0, 16'h01F5, 2'd0, 8'h00, "R4 base zero unmaps");
        cfg(6, 16'h01F0, 16'd8);
        acc(0, 16'h01F5, 2'd0, 8'h00, "R4 index 6 ignored");
        idle(4);

        total++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 leftover act=%0d exp=0", exp_q.size());
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule